// File: doc/BRIEF.md
# Boot Strap Capture Register

This block takes the board-level configuration strap pins of a switch and turns them into the configuration the rest of the chip uses. The pins are a global reference clock frequency select, a 3-bit port clocking mode and six port-pair merge enables. They pass through a two-flop synchroniser. The synchronised value is recorded only while the switch-wide fundamental reset is asserted. The value held at the edge where that reset drops is the sampled vector. From then on the pins are ignored.

A small register bus gives software read and write access. A read-only status word always reports the sampled vector. The clocking mode can be overridden through a lockable register that is loaded from the strap. The frequency select and merge enables cannot be changed. Two scratch fields show the other retention classes. One is sticky: it clears only on the switch or partition fundamental reset. The other is ordinary: it clears on any of the three resets. Every reset is synchronous and active-high. Bus writes issued while any reset is asserted are dropped.

Top module: `strap_cfg_capture`

## Requirements
- R1: While `sw_rst` is high and the straps are stable for at least three cycles, the status word (address 0) reports the sampled vector when read after the reset. Bit 0 holds the frequency select, bits 3:1 hold the clock mode, and bits 9:4 hold the merge enables for pairs 0/1, 2/3, 4/5, 6/7, 8/9 and 12/13, lowest bit first. All other bits read as 0.
- R2: Once `sw_rst` is low, strap pin changes have no effect on the status word or on any configuration output.
- R3: After a switch fundamental reset, `clk_mode_o` equals the sampled clock mode. While the block is unlocked, a write to address 1 replaces `clk_mode_o` with `wr_data[2:0]`, and the status word keeps the strap value.
- R4: `freq_sel_o` and `merge_en_o` always equal the sampled straps. A write to address 0 has no effect on the status word or on these outputs.
- R5: The sticky field (address 1 is clock mode; the sticky field is at address 3, full data width) clears on `sw_rst` or `part_rst` and keeps its value through `hot_rst`.
- R6: The clock mode register at address 1 keeps its value through `part_rst` and `hot_rst`. On `sw_rst` it reloads from the strap.
- R7: The lock bit is address 2, bit 0. While it is 1, writes to address 1 are silently dropped. Any of the three resets clears the lock to 0.
- R8: The ordinary field at address 4 (full data width) clears to 0 on any of `sw_rst`, `part_rst` or `hot_rst`.
- R9: A read that is accepted on one clock edge returns its data on `rd_data` with `rd_valid` high after that edge. A read of any address above 4 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sw_rst | input | 1 | Switch fundamental reset, synchronous, active-high; strap sampling window |
| part_rst | input | 1 | Partition fundamental reset, synchronous, active-high |
| hot_rst | input | 1 | Hot/soft reset, synchronous, active-high |
| strap_freq_i | input | 1 | Raw global clock frequency select pin |
| strap_mode_i | input | 3 | Raw port clocking mode pins |
| strap_merge_i | input | 6 | Raw merge enable pins, pairs 0/1 up to 12/13 |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Bus register address |
| wr_data | input | DATA_W | Bus write data |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| freq_sel_o | output | 1 | Effective frequency select |
| clk_mode_o | output | 3 | Effective port clocking mode |
| merge_en_o | output | 6 | Effective merge enables |

## Verification
The assertions assume the three resets are synchronous pulses of at least one cycle. They assume `sw_rst` is high from time zero, so every register has been loaded before any past-value comparison counts. They also assume reads are not issued during a reset. The stimulus holds `sw_rst` for six cycles and holds the straps steady across that window so the synchroniser settles. It then changes the pins only after release, drives the bus only on falling edges, and never overlaps a read or write with a reset pulse.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
  parameter int unsigned MODE_W = 3;
  parameter int unsigned PAIR_N = 6;
  localparam int unsigned STRAP_W = 1 + MODE_W + PAIR_N;

  typedef struct packed {
    logic [PAIR_N-1:0] merge;
    logic [MODE_W-1:0] mode;
    logic              freq;
  } strap_t;

  typedef enum logic [2:0] {
    RA_STATUS  = 3'd0,
    RA_CLKMODE = 3'd1,
    RA_LOCK    = 3'd2,
    RA_STICKY  = 3'd3,
    RA_PLAIN   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned WIDTH  = 10,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      chain_q <= {chain_q[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_cfg_pkg::*;
(
  input  logic   clk,
  input  logic   sw_rst,
  input  strap_t sync_i,
  output strap_t cap_o
);
  strap_t cap_q;

  // Tracks the synchronised pins for the whole reset window; the last
  // value before release is the one retained.
  always_ff @(posedge clk) begin
    if (sw_rst) cap_q <= sync_i;
  end

  assign cap_o = cap_q;

  p_status_hold_r2: assert property (@(posedge clk) disable iff (sw_rst)
    !$past(sw_rst) |-> $stable(cap_q))
    else $error("sampled vector moved outside switch reset (R2)");
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import strap_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              sw_rst,
  input  logic              part_rst,
  input  logic              hot_rst,
  input  strap_t            status_i,
  input  logic [MODE_W-1:0] strap_mode_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [MODE_W-1:0] clk_mode_o
);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(RA_STATUS);
  localparam logic [ADDR_W-1:0] A_CLKMODE = ADDR_W'(RA_CLKMODE);
  localparam logic [ADDR_W-1:0] A_LOCK    = ADDR_W'(RA_LOCK);
  localparam logic [ADDR_W-1:0] A_STICKY  = ADDR_W'(RA_STICKY);
  localparam logic [ADDR_W-1:0] A_PLAIN   = ADDR_W'(RA_PLAIN);

  logic              any_rst, wr_ok;
  logic [MODE_W-1:0] mode_q;
  logic              lock_q;
  logic [DATA_W-1:0] sticky_q, plain_q, rd_mux;
  logic              unused_wr_bits;

  assign any_rst = sw_rst | part_rst | hot_rst;
  assign wr_ok   = wr_en & ~any_rst;
  assign unused_wr_bits = &{1'b0, wr_data[DATA_W-1:MODE_W]};

  // Lock-writable: only the switch fundamental reset reloads it.
  always_ff @(posedge clk) begin
    if (sw_rst)
      mode_q <= strap_mode_i;
    else if (wr_ok && addr == A_CLKMODE && !lock_q)
      mode_q <= wr_data[MODE_W-1:0];
  end

  // Ordinary class: every reset clears.
  always_ff @(posedge clk) begin
    if (any_rst) begin
      lock_q  <= 1'b0;
      plain_q <= '0;
    end else if (wr_ok) begin
      if (addr == A_LOCK)  lock_q  <= wr_data[0];
      if (addr == A_PLAIN) plain_q <= wr_data;
    end
  end

  // Sticky class: fundamental resets only.
  always_ff @(posedge clk) begin
    if (sw_rst || part_rst)
      sticky_q <= '0;
    else if (wr_ok && addr == A_STICKY)
      sticky_q <= wr_data;
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_STATUS:  rd_mux[STRAP_W-1:0] = status_i;
      A_CLKMODE: rd_mux[MODE_W-1:0]  = mode_q;
      A_LOCK:    rd_mux[0]           = lock_q;
      A_STICKY:  rd_mux              = sticky_q;
      A_PLAIN:   rd_mux              = plain_q;
      default:   rd_mux              = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (any_rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  assign clk_mode_o = mode_q;

  p_sticky_keep_r5: assert property (@(posedge clk) disable iff (sw_rst)
    ($past(hot_rst) && !$past(part_rst) && !$past(sw_rst)) |-> $stable(sticky_q))
    else $error("sticky field changed across hot reset (R5)");

  p_rwl_keep_r6: assert property (@(posedge clk) disable iff (sw_rst)
    ($past(part_rst || hot_rst) && !$past(sw_rst)) |-> $stable(mode_q))
    else $error("clock mode changed across partition/hot reset (R6)");

  p_lock_drop_r7: assert property (@(posedge clk) disable iff (sw_rst)
    ($past(lock_q) && !$past(sw_rst)) |-> $stable(mode_q))
    else $error("clock mode written while locked (R7)");

  p_plain_clear_r8: assert property (@(posedge clk) disable iff (sw_rst)
    $past(part_rst || hot_rst) |-> (plain_q == '0))
    else $error("ordinary field survived a reset (R8)");

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (sw_rst)
    ($past(rd_en && addr > A_PLAIN) && !$past(part_rst || hot_rst))
      |-> (rd_valid && rd_data == '0))
    else $error("unmapped read returned data (R9)");
endmodule

// File: rtl/strap_cfg_capture.sv
module strap_cfg_capture
  import strap_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              sw_rst,
  input  logic              part_rst,
  input  logic              hot_rst,
  input  logic              strap_freq_i,
  input  logic [MODE_W-1:0] strap_mode_i,
  input  logic [PAIR_N-1:0] strap_merge_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              freq_sel_o,
  output logic [MODE_W-1:0] clk_mode_o,
  output logic [PAIR_N-1:0] merge_en_o
);
  strap_t pins_raw, pins_sync, sampled;

  assign pins_raw = '{merge: strap_merge_i, mode: strap_mode_i, freq: strap_freq_i};

  strap_sync #(.WIDTH(STRAP_W), .STAGES(2)) u_sync (
    .clk (clk),
    .din (pins_raw),
    .dout(pins_sync)
  );

  strap_capture u_cap (
    .clk   (clk),
    .sw_rst(sw_rst),
    .sync_i(pins_sync),
    .cap_o (sampled)
  );

  cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .sw_rst      (sw_rst),
    .part_rst    (part_rst),
    .hot_rst     (hot_rst),
    .status_i    (sampled),
    .strap_mode_i(pins_sync.mode),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .clk_mode_o  (clk_mode_o)
  );

  assign freq_sel_o = sampled.freq;
  assign merge_en_o = sampled.merge;

  p_fixed_outs_r4: assert property (@(posedge clk) disable iff (sw_rst)
    !$past(sw_rst) |-> ($stable(merge_en_o) && $stable(freq_sel_o)))
    else $error("non-overridable output changed (R4)");
endmodule

// File: tb/strap_cfg_capture_tb_top.sv
module strap_cfg_capture_tb_top;
  import strap_cfg_pkg::*;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              sw_rst = 1'b1, part_rst = 1'b0, hot_rst = 1'b0;
  logic              strap_freq_i = 1'b1;
  logic [MODE_W-1:0] strap_mode_i = 3'b101;
  logic [PAIR_N-1:0] strap_merge_i = 6'b100110;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              rd_valid;
  logic              freq_sel_o;
  logic [MODE_W-1:0] clk_mode_o;
  logic [PAIR_N-1:0] merge_en_o;

  strap_cfg_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (.*);

  int n_cmp = 0;
  int n_bad = 0;
  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp,
                       input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  // Driver: queue the expectation, then issue the read.
  task automatic bus_rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp,
                        input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    tick();
    rd_en = 1'b0;
  endtask

  // Monitor: pop and compare as read data appears.
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R9: unexpected read data 0x%0h expected none", rd_data);
      end else begin
        check(rd_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic pulse_rst(input int which, input int n);
    if (which == 0) sw_rst = 1'b1;
    else if (which == 1) part_rst = 1'b1;
    else hot_rst = 1'b1;
    repeat (n) tick();
    sw_rst = 1'b0; part_rst = 1'b0; hot_rst = 1'b0;
    tick();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (6) tick();
    sw_rst = 1'b0;
    tick();
    // Reset state, first strap vector: status 0x26B
    check(DATA_W'(clk_mode_o), 16'h5, "R3 clk_mode after strap");
    check(DATA_W'(freq_sel_o), 16'h1, "R4 freq_sel");
    check(DATA_W'(merge_en_o), 16'h26, "R4 merge_en");
    bus_rd(4'd0, 16'h026B, "R1 status word");
    bus_rd(4'd2, 16'h0, "R7 lock after reset");
    bus_rd(4'd3, 16'h0, "R5 sticky after reset");
    bus_rd(4'd4, 16'h0, "R8 plain after reset");

    // Pins move after reset
    strap_freq_i = 1'b0; strap_mode_i = 3'b000; strap_merge_i = 6'b011001;
    repeat (5) tick();
    bus_rd(4'd0, 16'h026B, "R2 status ignores pins");
    check(DATA_W'(merge_en_o), 16'h26, "R2 merge ignores pins");
    check(DATA_W'(freq_sel_o), 16'h1, "R2 freq ignores pins");
    check(DATA_W'(clk_mode_o), 16'h5, "R2 mode ignores pins");

    // Override clock mode
    bus_wr(4'd1, 16'h0002);
    check(DATA_W'(clk_mode_o), 16'h2, "R3 clk_mode override");
    bus_rd(4'd1, 16'h2, "R3 clk_mode readback");
    bus_rd(4'd0, 16'h026B, "R3 status keeps strap");

    // Status write and unmapped access
    bus_wr(4'd0, 16'hFFFF);
    bus_rd(4'd0, 16'h026B, "R4 status write ignored");
    check(DATA_W'(merge_en_o), 16'h26, "R4 merge after status write");
    bus_wr(4'd7, 16'hBEEF);
    bus_rd(4'd7, 16'h0, "R9 unmapped read");
    bus_rd(4'd15, 16'h0, "R9 unmapped top read");

    // Hot reset
    bus_wr(4'd3, 16'h00A5);
    bus_wr(4'd4, 16'h005A);
    bus_rd(4'd4, 16'h005A, "R8 plain written");
    pulse_rst(2, 2);
    bus_rd(4'd3, 16'h00A5, "R5 sticky kept on hot reset");
    bus_rd(4'd4, 16'h0, "R8 plain cleared by hot reset");
    check(DATA_W'(clk_mode_o), 16'h2, "R6 mode kept on hot reset");

    // Partition reset
    bus_wr(4'd4, 16'h0033);
    pulse_rst(1, 2);
    bus_rd(4'd3, 16'h0, "R5 sticky cleared by partition reset");
    bus_rd(4'd4, 16'h0, "R8 plain cleared by partition reset");
    check(DATA_W'(clk_mode_o), 16'h2, "R6 mode kept on partition reset");
    bus_rd(4'd0, 16'h026B, "R2 status kept on partition reset");

    // Lock
    bus_wr(4'd2, 16'h0001);
    bus_wr(4'd1, 16'h0007);
    check(DATA_W'(clk_mode_o), 16'h2, "R7 locked write dropped");
    bus_rd(4'd2, 16'h1, "R7 lock readback");
    pulse_rst(2, 1);
    bus_rd(4'd2, 16'h0, "R7 lock cleared by hot reset");
    bus_wr(4'd1, 16'h0004);
    check(DATA_W'(clk_mode_o), 16'h4, "R7 write after unlock");

    // Switch reset with new straps (0x196)
    bus_wr(4'd3, 16'h0077);
    strap_freq_i = 1'b0; strap_mode_i = 3'b011; strap_merge_i = 6'b011001;
    pulse_rst(0, 6);
    bus_rd(4'd0, 16'h0196, "R1 status resampled");
    check(DATA_W'(clk_mode_o), 16'h3, "R6 mode reloaded by switch reset");
    check(DATA_W'(freq_sel_o), 16'h0, "R4 freq resampled");
    check(DATA_W'(merge_en_o), 16'h19, "R4 merge resampled");
    bus_rd(4'd3, 16'h0, "R5 sticky cleared by switch reset");

    repeat (3) tick();
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R9: actual %0d reads pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule